// File: doc/BRIEF.md
# Radix-2 Complex Butterfly with Shared Multipliers

This block is the arithmetic core of one decimation-in-frequency FFT stage. Each enabled clock it accepts two complex samples, A (the earlier one) and B (the one half a span later), and a complex twiddle coefficient C. From these it forms two complex results: the sum A+B, and the difference A−B multiplied by C. Both results are scaled, rounded to the output width and presented together in the same cycle. A sync flag that comes in with the first pair of a transform goes through the pipeline and leaves with that pair's results.

The pipeline moves only on clocks where `ce` is high, so the block can run at any fraction of the clock rate. The parameter `CKPCE` states how many clocks at least separate two enables. With `CKPCE`=1 the complex product uses three real multipliers. With 2 it uses two, and with 3 it uses one, because partial products are computed during the idle clocks the caller guarantees. The reordering memories, the coefficient store and the stage sequencing sit outside the block.

Top module: `bfly_r2`

## Requirements
- R1: Each component of `sum_out` equals the convergent-rounded value of (A+B)·2^(CW−2)·2^SHIFT / 2^DROP, wrapped to OW bits, where DROP = CW−2+IW+1−OW−SHIFT (with the default widths this is exactly A+B).
- R2: The coefficient is signed with unity at 2^(CW−2). Each component of `prod_out` equals the convergent-rounded value of (A−B)·C·2^SHIFT / 2^DROP, wrapped to OW bits, using real = dr·cr − di·ci and imag = dr·ci + di·cr.
- R3: Every complex word (`a_in`, `b_in`, `coef_in`, `sum_out`, `prod_out`) carries the real part in its upper half and the imaginary part in its lower half, each in two's complement.
- R4: Rounding is round-half-to-even on the discarded bits: a remainder above one half rounds up, below one half rounds down, and exactly one half rounds to the even result.
- R5: The results for a pair captured at one enabled edge appear on the outputs just after the second enabled edge that follows it (three enabled edges in total, counting the capture edge).
- R6: `sync_out` is high exactly in the output cycles that hold the results of a pair captured with `sync_in` high, and low in all other cycles.
- R7: On an edge where `ce` is low, `sum_out`, `prod_out` and `sync_out` keep their values.
- R8: A synchronous reset clears the sync path, so `sync_out` is low in the cycle after reset and stays low until a marked pair has gone through.
- R9: With `CKPCE`=2, the caller leaves at least one clock with `ce` low between enables. The product then uses two real multipliers and gives the same results as in R2.
- R10: With `CKPCE`=3, the caller leaves at least two clocks with `ce` low between enables. The product then uses one time-shared multiplier and gives the same results as in R2.
- R11: With `CKPCE`=1, `ce` may be high on consecutive clocks. The product then uses three real multipliers and gives the same results as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; the pipeline advances only when high |
| sync_in | input | 1 | Marks the first pair of a transform; sampled with `ce` |
| a_in | input | 2*IW | Earlier complex sample A |
| b_in | input | 2*IW | Later complex sample B |
| coef_in | input | 2*CW | Twiddle coefficient C |
| sum_out | output | 2*OW | Rounded A+B |
| prod_out | output | 2*OW | Rounded (A−B)·C |
| sync_out | output | 1 | Marks the results of the first pair |

## Verification
The checker assumes that `ce` keeps the idle gap required by `CKPCE` and stays low while reset is applied. The sync model in the checker also assumes that `sync_in` matters only on enabled clocks. The bench driver adds the minimum number of low-`ce` clocks for each mode, plus random extra gaps and one long stall. It changes `sync_in` only together with an enabled capture, and it holds `ce` low while reset is applied between modes. Because the shared-multiplier modes depend on the idle-clock rule, they are driven only with gaps that respect it.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // enabled edges from capture to visible result
  localparam int unsigned BFLY_STAGES = 3;
  // clocks elapsed since the last enable, saturating
  typedef logic [1:0] phase_t;
  localparam phase_t PH_SLOT0 = 2'd0;
  localparam phase_t PH_SLOT1 = 2'd1;
  localparam phase_t PH_LAST  = 2'd3;
endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int IW = 15
) (
  input  logic                 clk,
  input  logic                 ce,
  input  logic [2*IW-1:0]      a_in,
  input  logic [2*IW-1:0]      b_in,
  output logic signed [IW:0]   sr,
  output logic signed [IW:0]   si,
  output logic signed [IW:0]   dr,
  output logic signed [IW:0]   di
);
  logic signed [IW:0] ar, ai, br, bi;

  // sign-extend each component by one bit of headroom
  assign ar = {a_in[2*IW-1], a_in[2*IW-1:IW]};
  assign ai = {a_in[IW-1],   a_in[IW-1:0]};
  assign br = {b_in[2*IW-1], b_in[2*IW-1:IW]};
  assign bi = {b_in[IW-1],   b_in[IW-1:0]};

  always_ff @(posedge clk) begin
    if (ce) begin
      sr <= ar + br;
      si <= ai + bi;
      dr <= ar - br;
      di <= ai - bi;
    end
  end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul
  import bfly_pkg::*;
#(
  parameter int IW    = 15,
  parameter int CW    = 20,
  parameter int CKPCE = 3,
  localparam int FW   = IW + CW + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic signed [IW:0]    dr,
  input  logic signed [IW:0]    di,
  input  logic signed [CW-1:0]  cr,
  input  logic signed [CW-1:0]  ci,
  output logic signed [FW-1:0]  pr,
  output logic signed [FW-1:0]  pi
);
  logic signed [IW+1:0] dsum;
  logic signed [CW:0]   csum;

  assign dsum = {dr[IW], dr} + {di[IW], di};
  assign csum = {cr[CW-1], cr} + {ci[CW-1], ci};

  generate
    if (CKPCE == 1) begin : g_three
      // three multipliers, all results valid in the enabled clock
      logic signed [FW-1:0] m_rr, m_ii, m_ss;
      assign m_rr = FW'(dr) * FW'(cr);
      assign m_ii = FW'(di) * FW'(ci);
      assign m_ss = FW'(dsum) * FW'(csum);
      assign pr = m_rr - m_ii;
      assign pi = m_ss - m_rr - m_ii;
    end else begin : g_shared
      phase_t ph;
      logic signed [FW-1:0] slot0, slot1;
      logic                 ld0, ld1;

      always_ff @(posedge clk) begin
        if (rst)             ph <= PH_SLOT0;
        else if (ce)         ph <= PH_SLOT0;
        else if (ph != PH_LAST) ph <= ph + 2'd1;
      end

      assign ld0 = !ce && (ph == PH_SLOT0);
      assign ld1 = !ce && (ph == PH_SLOT1);

      if (CKPCE == 2) begin : g_two
        // two multipliers: real terms on the idle clock, cross terms live
        logic signed [FW-1:0] mul_a, mul_b;
        assign mul_a = ce ? FW'(dr) * FW'(ci) : FW'(dr) * FW'(cr);
        assign mul_b = ce ? FW'(di) * FW'(cr) : FW'(di) * FW'(ci);
        always_ff @(posedge clk) begin
          if (ld0) begin
            slot0 <= mul_a;
            slot1 <= mul_b;
          end
        end
        assign pr = slot0 - slot1;
        assign pi = mul_a + mul_b;
      end else begin : g_one
        // one multiplier: rr, then ii, then the cross sum when enabled
        logic signed [IW+1:0] opa;
        logic signed [CW:0]   opb;
        logic signed [FW-1:0] mul;
        always_comb begin
          if (ce) begin
            opa = dsum;
            opb = csum;
          end else if (ph == PH_SLOT0) begin
            opa = {dr[IW], dr};
            opb = {cr[CW-1], cr};
          end else begin
            opa = {di[IW], di};
            opb = {ci[CW-1], ci};
          end
        end
        assign mul = FW'(opa) * FW'(opb);
        always_ff @(posedge clk) begin
          if (ld0) slot0 <= mul;
          if (ld1) slot1 <= mul;
        end
        assign pr = slot0 - slot1;
        assign pi = mul - slot0 - slot1;
      end
    end
  endgenerate
endmodule

// File: rtl/bfly_round.sv
module bfly_round #(
  parameter int FW    = 38,
  parameter int OW    = 16,
  parameter int SHIFT = 0,
  parameter int DROP  = 18
) (
  input  logic signed [FW-1:0] x,
  output logic [OW-1:0]        y
);
  localparam int KW = FW - DROP;

  logic [FW-1:0]   xs;
  logic [DROP-1:0] frac, rest;
  logic            up;

  always_comb begin
    xs   = x << SHIFT;
    frac = xs[DROP-1:0];
    rest = frac;
    rest[DROP-1] = 1'b0;
    // above half, or exactly half with an odd kept value
    up   = frac[DROP-1] & ((|rest) | xs[DROP]);
    y    = OW'(xs[FW-1:DROP] + KW'(up));
  end
endmodule

// File: rtl/bfly_r2.sv
module bfly_r2
  import bfly_pkg::*;
#(
  parameter int IW    = 15,
  parameter int CW    = 20,
  parameter int OW    = 16,
  parameter int SHIFT = 0,
  parameter int CKPCE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sync_in,
  input  logic [2*IW-1:0]   a_in,
  input  logic [2*IW-1:0]   b_in,
  input  logic [2*CW-1:0]   coef_in,
  output logic [2*OW-1:0]   sum_out,
  output logic [2*OW-1:0]   prod_out,
  output logic              sync_out
);
  localparam int FW   = IW + CW + 3;
  localparam int DROP = CW - 2 + IW + 1 - OW - SHIFT;
  localparam int NL   = 4;

  // stage 1
  logic signed [IW:0]   s1r, s1i, d1r, d1i;
  logic signed [CW-1:0] c1r, c1i;

  bfly_addsub #(.IW(IW)) u_addsub (
    .clk(clk), .ce(ce), .a_in(a_in), .b_in(b_in),
    .sr(s1r), .si(s1i), .dr(d1r), .di(d1i)
  );

  always_ff @(posedge clk) begin
    if (ce) begin
      c1r <= coef_in[2*CW-1:CW];
      c1i <= coef_in[CW-1:0];
    end
  end

  // stage 2
  logic signed [FW-1:0] pr, pi;
  logic signed [FW-1:0] p2r, p2i;
  logic signed [IW:0]   s2r, s2i;

  bfly_cmul #(.IW(IW), .CW(CW), .CKPCE(CKPCE)) u_cmul (
    .clk(clk), .rst(rst), .ce(ce),
    .dr(d1r), .di(d1i), .cr(c1r), .ci(c1i),
    .pr(pr), .pi(pi)
  );

  always_ff @(posedge clk) begin
    if (ce) begin
      p2r <= pr;
      p2i <= pi;
      s2r <= s1r;
      s2i <= s1i;
    end
  end

  // stage 3: align both paths to the same fixed point, round, register
  logic signed [FW-1:0] lane_in [NL];
  logic [OW-1:0]        lane_out[NL];

  assign lane_in[0] = FW'(s2r) <<< (CW - 2);
  assign lane_in[1] = FW'(s2i) <<< (CW - 2);
  assign lane_in[2] = p2r;
  assign lane_in[3] = p2i;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    bfly_round #(.FW(FW), .OW(OW), .SHIFT(SHIFT), .DROP(DROP)) u_rnd (
      .x(lane_in[k]), .y(lane_out[k])
    );
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      sum_out  <= {lane_out[0], lane_out[1]};
      prod_out <= {lane_out[2], lane_out[3]};
    end
  end

  // sync marker walks beside the data
  logic [BFLY_STAGES-1:0] sync_pipe;

  always_ff @(posedge clk) begin
    if (rst)     sync_pipe <= '0;
    else if (ce) sync_pipe <= {sync_pipe[BFLY_STAGES-2:0], sync_in};
  end

  assign sync_out = sync_pipe[BFLY_STAGES-1];
endmodule

// File: rtl/bfly_r2_chk.sv
module bfly_r2_chk #(
  parameter int OW    = 16,
  parameter int CKPCE = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            ce,
  input logic            sync_in,
  input logic [2*OW-1:0] sum_out,
  input logic [2*OW-1:0] prod_out,
  input logic            sync_out
);
  // independent count of enabled edges since each marked capture
  logic [2:0] mark_age;
  always_ff @(posedge clk) begin
    if (rst)     mark_age <= '0;
    else if (ce) mark_age <= {mark_age[1:0], sync_in};
  end

  // R8
  sync_reset_chk: assert property (@(posedge clk) rst |=> !sync_out);

  // R6
  sync_align_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out == mark_age[2]);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(sum_out) && $stable(prod_out) && $stable(sync_out)));

  // R9
  gap_one_chk: assert property (@(posedge clk) disable iff (rst)
    (CKPCE >= 2 && ce) |=> !ce);

  // R10
  gap_two_chk: assert property (@(posedge clk) disable iff (rst)
    (CKPCE == 3 && ce) |=> !ce ##1 !ce);
endmodule

bind bfly_r2 bfly_r2_chk #(.OW(OW), .CKPCE(CKPCE)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .sync_in(sync_in),
  .sum_out(sum_out), .prod_out(prod_out), .sync_out(sync_out)
);

// File: tb/test_bfly_r2.sv
`timescale 1ns/100ps
module test_bfly_r2;
  localparam int IW = 15, CW = 20, OW = 16, SHIFT = 0;
  localparam int DROP = CW - 2 + IW + 1 - OW - SHIFT;

  typedef struct {
    logic [2*OW-1:0] s;
    logic [2*OW-1:0] p;
    logic            y;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] ce_v = '0;
  logic sync_in = 1'b0;
  logic [2*IW-1:0] a_in = '0, b_in = '0;
  logic [2*CW-1:0] c_in = '0;
  logic [2*OW-1:0] s_o[3], p_o[3];
  logic            y_o[3];

  exp_t q[$];
  int cur = 0, nen = 0, errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bfly_r2 #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SHIFT), .CKPCE(1)) i_bfly_r2 (
    .clk(clk), .rst(rst), .ce(ce_v[0]), .sync_in(sync_in), .a_in(a_in), .b_in(b_in),
    .coef_in(c_in), .sum_out(s_o[0]), .prod_out(p_o[0]), .sync_out(y_o[0]));
  bfly_r2 #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SHIFT), .CKPCE(2)) i_bfly_r2_m2 (
    .clk(clk), .rst(rst), .ce(ce_v[1]), .sync_in(sync_in), .a_in(a_in), .b_in(b_in),
    .coef_in(c_in), .sum_out(s_o[1]), .prod_out(p_o[1]), .sync_out(y_o[1]));
  bfly_r2 #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SHIFT), .CKPCE(3)) i_bfly_r2_m3 (
    .clk(clk), .rst(rst), .ce(ce_v[2]), .sync_in(sync_in), .a_in(a_in), .b_in(b_in),
    .coef_in(c_in), .sum_out(s_o[2]), .prod_out(p_o[2]), .sync_out(y_o[2]));

  // convergent rounding, R4
  function automatic logic [OW-1:0] rnd(longint v);
    longint v2, t, fr, half;
    v2   = v <<< SHIFT;
    t    = v2 >>> DROP;
    fr   = v2 & ((64'sd1 <<< DROP) - 1);
    half = 64'sd1 <<< (DROP - 1);
    if (fr > half || (fr == half && t[0])) t = t + 1;
    return t[OW-1:0];
  endfunction

  // R1 R2 R3 reference
  function automatic exp_t model(logic [2*IW-1:0] a, logic [2*IW-1:0] b,
                                 logic [2*CW-1:0] c, logic s);
    exp_t e;
    longint ar, ai, br, bi, cr, ci, dr, di;
    ar = longint'($signed(a[2*IW-1:IW])); ai = longint'($signed(a[IW-1:0]));
    br = longint'($signed(b[2*IW-1:IW])); bi = longint'($signed(b[IW-1:0]));
    cr = longint'($signed(c[2*CW-1:CW])); ci = longint'($signed(c[CW-1:0]));
    dr = ar - br; di = ai - bi;
    e.s = {rnd((ar + br) <<< (CW - 2)), rnd((ai + bi) <<< (CW - 2))};
    e.p = {rnd(dr * cr - di * ci), rnd(dr * ci + di * cr)};
    e.y = s;
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s mode %0d: got %h expected %h", req, cur + 1, got, expv);
    end
  endtask

  function automatic string mode_tag();
    return (cur == 0) ? "R11" : (cur == 1) ? "R9" : "R10";
  endfunction

  // driver: one capture, then gap idle clocks with junk on the inputs
  task automatic issue(logic [2*IW-1:0] a, logic [2*IW-1:0] b,
                       logic [2*CW-1:0] c, logic s, int gap);
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; sync_in = s;
    ce_v = '0; ce_v[cur] = 1'b1;
    q.push_back(model(a, b, c, s));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      ce_v = '0; sync_in = 1'b0;
      a_in = $urandom; b_in = $urandom; c_in = {$urandom, $urandom};
    end
  endtask

  // monitor
  initial begin
    logic [2*OW-1:0] ps, pp;
    logic py;
    ps = '0; pp = '0; py = 1'b0;
    forever begin
      @(posedge clk);
      if (!rst && ce_v[cur]) begin
        @(negedge clk);
        if (nen >= 2) begin
          exp_t e;
          e = q.pop_front();
          chk("R1/R3/R5", 64'(s_o[cur]), 64'(e.s));
          chk({"R2/R4 ", mode_tag()}, 64'(p_o[cur]), 64'(e.p));
          chk("R6", 64'(y_o[cur]), 64'(e.y));
        end
        nen++;
        ps = s_o[cur]; pp = p_o[cur]; py = y_o[cur];
      end else if (!rst && nen > 0) begin
        @(negedge clk);
        // R7: an idle edge leaves every output alone
        chk("R7", {s_o[cur], p_o[cur]}, {ps, pp});
        chk("R7", 64'(y_o[cur]), 64'(py));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      ce_v = '0; rst = 1'b1; cur = m;
      repeat (3) @(negedge clk);
      nen = 0; q.delete();
      rst = 1'b0;
      @(negedge clk);
      // R8: no marker after reset
      chk("R8", 64'(y_o[m]), 64'd0);
      // corners: half-way rounding with coefficient 0.5 (R4)
      issue({15'sd3, -15'sd5}, '0, {20'sd131072, 20'sd0}, 1'b1, m);
      issue({-15'sd7, 15'sd9}, '0, {20'sd131072, 20'sd0}, 1'b0, m);
      // unity coefficient, extremes of the input range
      issue({15'h3fff, 15'h4000}, {15'h4000, 15'h3fff}, {20'sd262144, 20'sd0}, 1'b0, m);
      issue({15'h3fff, 15'h3fff}, {15'h3fff, 15'h3fff}, {20'h80000, 20'h80000}, 1'b0, m);
      issue({15'h4000, 15'h3fff}, {15'h3fff, 15'h4000}, {20'h7ffff, 20'h80000}, 1'b0, m);
      // one long stall (R7)
      issue($urandom, $urandom, {$urandom, $urandom}, 1'b0, m + 6);
      for (int i = 0; i < 40; i++)
        issue($urandom, $urandom, {$urandom, $urandom}, (i == 20), m + int'($urandom_range(0, 1)));
      // flush
      issue('0, '0, '0, 1'b0, m);
      issue('0, '0, '0, 1'b0, m);
      issue('0, '0, '0, 1'b0, m);
      repeat (4) @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule